// File: doc/BRIEF.md
# Packed Horizontal Pair Add/Subtract Unit

This block reduces adjacent element pairs of two packed integer vectors. The vector is split into independent 128-bit lanes. In each lane, every even/odd element pair of the first operand is combined into one result element, and these results fill the lower half of the lane. The pairs of the second operand fill the upper half in the same way. The combining function is one of four: wrapping add, wrapping subtract, signed-saturating add and signed-saturating subtract. Saturation applies only when the elements are 16 bits wide.

The unit is a single pipeline stage with a valid/ready handshake on both sides. An operand set is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is shown on `out_valid`/`out_data` from the next cycle. It stays there, unchanged, until the consumer raises `out_ready`. `in_ready` is high whenever the output register is empty, or is being drained in the same cycle, so a full-rate stream flows with no bubbles. When `REG_OUT` is 0, the stage is a wire and the handshake passes straight through. The element width (16 or 32) and the vector width (a multiple of 128) are parameters.

Top module: `hpair_unit`

## Requirements
- R1: Each 128-bit lane is computed only from the same lane of `in_a` and `in_b`. No pair spans a lane boundary.
- R2: In lane L, the pair of `in_a` elements (2k, 2k+1) gives result element k of that lane, for k from 0 to half the lane's element count minus 1. Element i of a vector sits at bits i*ELEM_W upward.
- R3: In lane L, the pair of `in_b` elements (2k, 2k+1) gives result element k plus half the lane's element count.
- R4: For the subtracting codes, the result is the even element minus the odd element.
- R5: `in_op` 2'b00 adds and 2'b01 subtracts. Both wrap modulo 2^ELEM_W.
- R6: `in_op` 2'b10, with 16-bit elements, adds and clamps to the range 16'h8000 to 16'h7FFF.
- R7: `in_op` 2'b11, with 16-bit elements, subtracts and clamps to the range 16'h8000 to 16'h7FFF.
- R8: With 32-bit elements, codes 2'b10 and 2'b11 give the same wrapping results as 2'b00 and 2'b01.
- R9: An accepted operand set appears on `out_data` with `out_valid` high in the next cycle. `out_valid` drops after a transfer with no new acceptance.
- R10: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, `out_data` holds.
- R11: While `rst_n` is low, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set is offered |
| in_ready | output | 1 | Unit can take an operand set |
| in_a | input | VEC_W | First packed operand |
| in_b | input | VEC_W | Second packed operand |
| in_op | input | 2 | Function code: 00 add, 01 sub, 10 sat add, 11 sat sub |
| out_valid | output | 1 | Result is held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | VEC_W | Packed result |

## Verification
The bench drives pairs at 16'h7FFF and 16'h8000 in both directions, including minus one and plus one as the odd element. A design that used the wrong overflow sign would clamp the wrong way, and one that wrapped in the saturating codes would flip the sign. Index-numbered operands show whether the two sources are swapped, whether their halves are placed wrongly, or whether pairs are taken across lanes. A 32-bit instance fed the saturating codes catches a design that clamps at the wrong width. Random stalls on `out_ready` check that a held result does not change and that no result is lost or duplicated under back-pressure.

// File: rtl/hpair_pkg.sv
package hpair_pkg;
  localparam int LANE_W = 128;

  typedef enum logic [1:0] {
    HP_ADD  = 2'b00,
    HP_SUB  = 2'b01,
    HP_ADDS = 2'b10,
    HP_SUBS = 2'b11
  } hp_op_e;
endpackage

// File: rtl/hpair_pair_op.sv
module hpair_pair_op
  import hpair_pkg::*;
#(
  parameter int EW     = 16,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [EW-1:0] even_i,
  input  logic [EW-1:0] odd_i,
  input  hp_op_e        op_i,
  output logic [EW-1:0] res_o
);
  logic signed [EW:0] sum_w;
  logic signed [EW:0] dif_w;
  logic        [EW:0] sel_w;

  assign sum_w = $signed({even_i[EW-1], even_i}) + $signed({odd_i[EW-1], odd_i});
  assign dif_w = $signed({even_i[EW-1], even_i}) - $signed({odd_i[EW-1], odd_i});
  assign sel_w = op_i[0] ? dif_w : sum_w;

  generate
    if (SAT_OK) begin : g_sat
      logic ovf_w;
      assign ovf_w = sel_w[EW] ^ sel_w[EW-1];
      always_comb begin
        if (op_i[1] && ovf_w)
          res_o = sel_w[EW] ? {1'b1, {(EW-1){1'b0}}} : {1'b0, {(EW-1){1'b1}}};
        else
          res_o = sel_w[EW-1:0];
      end
    end else begin : g_wrap
      logic unused_hi;
      assign unused_hi = op_i[1] ^ sel_w[EW];
      assign res_o = sel_w[EW-1:0];
    end
  endgenerate
endmodule

// File: rtl/hpair_lane.sv
module hpair_lane
  import hpair_pkg::*;
#(
  parameter int EW     = 16,
  parameter bit SAT_OK = 1'b1
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  hp_op_e            op_i,
  output logic [LANE_W-1:0] res_o
);
  localparam int EPL  = LANE_W / EW;
  localparam int HALF = EPL / 2;

  generate
    for (genvar k = 0; k < HALF; k++) begin : g_pair
      hpair_pair_op #(.EW(EW), .SAT_OK(SAT_OK)) u_a (
        .even_i(a_i[(2*k)*EW +: EW]),
        .odd_i (a_i[(2*k+1)*EW +: EW]),
        .op_i  (op_i),
        .res_o (res_o[k*EW +: EW])
      );
      hpair_pair_op #(.EW(EW), .SAT_OK(SAT_OK)) u_b (
        .even_i(b_i[(2*k)*EW +: EW]),
        .odd_i (b_i[(2*k+1)*EW +: EW]),
        .op_i  (op_i),
        .res_o (res_o[(HALF+k)*EW +: EW])
      );
    end
  endgenerate
endmodule

// File: rtl/hpair_stage.sv
module hpair_stage #(
  parameter int W   = 256,
  parameter bit REG = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  generate
    if (REG) begin : g_reg
      logic         v_q;
      logic [W-1:0] d_q;

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
        end else if (in_valid && in_ready) begin
          v_q <= 1'b1;
        end else if (out_ready) begin
          v_q <= 1'b0;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) d_q <= in_data;
      end

      // R10
      hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
      // R9
      accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);
      // R9
      drain_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
      // R10
      empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready);
    end else begin : g_wire
      logic unused_ck;
      assign unused_ck = clk ^ rst_n;
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/hpair_unit.sv
module hpair_unit
  import hpair_pkg::*;
#(
  parameter int VEC_W   = 256,
  parameter int ELEM_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_a,
  input  logic [VEC_W-1:0] in_b,
  input  logic [1:0]       in_op,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data
);
  localparam int LANES  = VEC_W / LANE_W;
  localparam bit SAT_OK = (ELEM_W == 16);

  hp_op_e           op_w;
  logic [VEC_W-1:0] res_w;

  assign op_w = hp_op_e'(in_op);

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      hpair_lane #(.EW(ELEM_W), .SAT_OK(SAT_OK)) u_lane (
        .a_i  (in_a[l*LANE_W +: LANE_W]),
        .b_i  (in_b[l*LANE_W +: LANE_W]),
        .op_i (op_w),
        .res_o(res_w[l*LANE_W +: LANE_W])
      );
    end
  endgenerate

  hpair_stage #(.W(VEC_W), .REG(REG_OUT)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (res_w),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data)
  );

  generate
    if (REG_OUT) begin : g_chk
      // R5
      add_elem0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b00) |=>
          out_data[ELEM_W-1:0] == $past(in_a[ELEM_W-1:0] + in_a[2*ELEM_W-1:ELEM_W]));
      // R4
      sub_elem0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_op == 2'b01) |=>
          out_data[ELEM_W-1:0] == $past(in_a[ELEM_W-1:0] - in_a[2*ELEM_W-1:ELEM_W]));
      if (SAT_OK) begin : g_satchk
        // R6
        sat_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
          (in_valid && in_ready && in_op == 2'b10 &&
           in_b[15:0] == 16'h7FFF && in_b[31:16] == 16'h7FFF) |=>
            out_data[(LANE_W/2) +: 16] == 16'h7FFF);
      end
    end
  endgenerate
endmodule

// File: tb/hpair_unit_bench.sv
`timescale 1ns/1ps
module hpair_unit_bench;
  localparam int VW = 256;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [VW-1:0] in_a, in_b;
  logic [1:0]    in_op;
  logic          out_ready;
  logic          in_ready, in_ready_w32;
  logic          out_valid, out_valid_w32;
  logic [VW-1:0] out_data, out_data_w32;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  bit            mv;
  logic [VW-1:0] md16, md32;
  logic [1:0]    mop;

  always #10 clk = ~clk;

  hpair_unit #(.VEC_W(VW), .ELEM_W(16)) u_hpair_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data));

  hpair_unit #(.VEC_W(VW), .ELEM_W(32)) u_hpair_unit_w32 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_w32),
    .in_a(in_a), .in_b(in_b), .in_op(in_op), .out_valid(out_valid_w32),
    .out_ready(out_ready), .out_data(out_data_w32));

  function automatic longint elem(input logic [VW-1:0] v, input int idx, input int ew);
    longint u = 0;
    for (int bt = 0; bt < ew; bt++) u[bt] = v[idx*ew+bt];
    if (u[ew-1]) u = u - (longint'(1) << ew);
    return u;
  endfunction

  function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                           input logic [1:0] op, input int ew);
    logic [VW-1:0] r = '0;
    int epl = 128 / ew;
    int half = epl / 2;
    for (int ln = 0; ln < VW/128; ln++)
      for (int s = 0; s < 2; s++)
        for (int k = 0; k < half; k++) begin
          logic [VW-1:0] src = (s == 1) ? b : a;
          longint x = elem(src, ln*epl + 2*k, ew);
          longint y = elem(src, ln*epl + 2*k + 1, ew);
          longint v = op[0] ? x - y : x + y;
          int dst = ln*epl + s*half + k;
          if (op[1] && ew == 16) begin
            if (v > 32767) v = 32767;
            if (v < -32768) v = -32768;
          end
          for (int bt = 0; bt < ew; bt++) r[dst*ew+bt] = v[bt];
        end
    return r;
  endfunction

  function automatic string tag_for(input logic [1:0] op, input int ew);
    if (ew == 32 && op[1]) return "R8 wide sat code wraps";
    case (op)
      2'b00:   return "R1/R2/R3/R5 add";
      2'b01:   return "R4/R5 sub";
      2'b10:   return "R6 sat add";
      default: return "R7 sat sub";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tg, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tg, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [VW-1:0] a, input logic [VW-1:0] b,
                      input logic [1:0] op, input logic ordy);
    logic rdy_exp;
    in_valid = v; in_a = a; in_b = b; in_op = op; out_ready = ordy;
    #1;
    rdy_exp = !mv || ordy;
    chk(in_ready == rdy_exp, "R10 in_ready", VW'(in_ready), VW'(rdy_exp));
    chk(in_ready_w32 == rdy_exp, "R10 in_ready wide", VW'(in_ready_w32), VW'(rdy_exp));
    @(negedge clk);
    if (v && rdy_exp) begin
      mv = 1'b1;
      md16 = ref_vec(a, b, op, 16);
      md32 = ref_vec(a, b, op, 32);
      mop = op;
    end else if (ordy) begin
      mv = 1'b0;
    end
    chk(out_valid == mv, "R9 out_valid", VW'(out_valid), VW'(mv));
    chk(out_valid_w32 == mv, "R9 out_valid wide", VW'(out_valid_w32), VW'(mv));
    if (mv) begin
      chk(out_data == md16, {tag_for(mop, 16), " / R10 hold"}, out_data, md16);
      chk(out_data_w32 == md32, tag_for(mop, 32), out_data_w32, md32);
    end
  endtask

  function automatic logic [VW-1:0] fill(input logic [15:0] ev, input logic [15:0] od);
    logic [VW-1:0] r;
    for (int i = 0; i < VW/32; i++) r[i*32 +: 32] = {od, ev};
    return r;
  endfunction

  function automatic logic [VW-1:0] rand_vec();
    logic [VW-1:0] r;
    for (int i = 0; i < VW/16; i++) begin
      case ($urandom % 6)
        0: r[i*16 +: 16] = 16'h7FFF;
        1: r[i*16 +: 16] = 16'h8000;
        2: r[i*16 +: 16] = 16'hFFFF;
        3: r[i*16 +: 16] = 16'h0001;
        default: r[i*16 +: 16] = 16'($urandom);
      endcase
    end
    return r;
  endfunction

  initial begin
    logic [VW-1:0] ia, ib;
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_op = 2'b00; out_ready = 1'b0;
    mv = 1'b0; md16 = '0; md32 = '0; mop = 2'b00;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid == 1'b0, "R11 reset out_valid", VW'(out_valid), '0);
    chk(out_valid_w32 == 1'b0, "R11 reset out_valid wide", VW'(out_valid_w32), '0);
    rst_n = 1'b1;

    // R1 R2 R3: index-numbered elements expose ordering and lane crossing
    for (int i = 0; i < VW/16; i++) begin
      ia[i*16 +: 16] = 16'(i + 1);
      ib[i*16 +: 16] = 16'(16'h0100 + i*3);
    end
    step(1'b1, ia, ib, 2'b00, 1'b1);
    step(1'b1, ia, ib, 2'b01, 1'b1);   // R4 order of operands
    step(1'b1, ia, ib, 2'b10, 1'b1);
    // R6 clamp high and low
    step(1'b1, fill(16'h7FFF, 16'h7FFF), fill(16'h7FFF, 16'h0001), 2'b10, 1'b1);
    step(1'b1, fill(16'h8000, 16'h8000), fill(16'h8000, 16'hFFFF), 2'b10, 1'b1);
    // R7 clamp low and high
    step(1'b1, fill(16'h8000, 16'h0001), fill(16'h7FFF, 16'hFFFF), 2'b11, 1'b1);
    // R5 same operands wrap
    step(1'b1, fill(16'h8000, 16'h0001), fill(16'h7FFF, 16'hFFFF), 2'b01, 1'b1);
    step(1'b1, fill(16'h7FFF, 16'h7FFF), fill(16'h8000, 16'h8000), 2'b00, 1'b1);
    // R8 wide instance under saturating codes
    step(1'b1, fill(16'hFFFF, 16'h7FFF), fill(16'h0000, 16'h8000), 2'b10, 1'b1);
    step(1'b1, fill(16'h0000, 16'h8000), fill(16'hFFFF, 16'h7FFF), 2'b11, 1'b1);
    // R10: stall with a held result, then drain
    step(1'b1, ia, ib, 2'b11, 1'b0);
    step(1'b1, ib, ia, 2'b00, 1'b0);
    step(1'b0, ia, ib, 2'b00, 1'b0);
    step(1'b0, ia, ib, 2'b00, 1'b1);
    step(1'b0, ia, ib, 2'b00, 1'b1);
    // random traffic with back-pressure
    for (int n = 0; n < 3000; n++)
      step(1'($urandom % 4 != 0), rand_vec(), rand_vec(), 2'($urandom), 1'($urandom % 3 != 0));
    step(1'b0, '0, '0, 2'b00, 1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule